// File: doc/BRIEF.md
# Delay-Line Calibration Table Builder

This block turns the live bin-occupancy histograms of two parallel tapped delay lines into calibrated fine times. Each histogram counts how many of the most recent hits fell into every bin, so a bin's count is proportional to its width. A pipelined Brent-Kung prefix adder per delay line computes every running sum of the bin counts in parallel. When its result emerges, the whole sum vector is copied at once into an active lookup table. A new histogram sample enters the network on every clock, so the table follows the counts continuously.

Events arrive as a bin code plus a select bit. The select bit says which delay line captured the hit, and so also whether the reference clock was high when the hit came. The block looks the code up in the active table of that line. It returns the sum of all lower bins plus half of the event's own bin. For the second line it also adds the clock-low interval. That interval is the window depth minus the duty count, clamped at zero. All terms use histogram count units, so a single scaling by period over window depth converts the result to time.

The event path has a fixed two-cycle latency and never stalls. There is no ready signal in either direction: an event is accepted in every cycle its valid is high, and the consumer must take each result in the cycle `fine_valid` is high, because results are never held back.

Top module: `calib_lut_builder`

## Requirements
- R1: With `ev_sel`=0 and `ev_code`=k, the result is the sum of the first-line counts of bins 0..k-1 plus floor(count of bin k / 2). Bin i sits at bits [i*CNT_W +: CNT_W] of `hist_a`.
- R2: With `ev_sel`=1, the same formula uses `hist_b` (packed the same way) and adds WIN_DEPTH − `duty_cnt`.
- R3: When `duty_cnt` is at or above WIN_DEPTH, the added clock-low interval is 0.
- R4: `fine_valid` is high exactly two rising edges after the edge that samples `ev_valid` high, and low otherwise. Events on consecutive cycles are all accepted and answered in order.
- R5: Let edge e0 be the first to sample a new histogram. An event sampled at edge e0+2·log2(NBINS) or later uses the new table. One sampled at edge e0+2·log2(NBINS)−1 or earlier still uses the previous table.
- R6: During reset and after it, `fine_valid` is low. Until the first table has been completed, the active table is all zero, so an event with `ev_sel`=0 returns 0.
- R7: With every count at its maximum value, the result for the top bin is exact, with no wrap.
- R8: All table entries are replaced in the same cycle. A lookup never combines entries derived from different histogram samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hist_a | input | NBINS*CNT_W | Live bin counts of the first delay line |
| hist_b | input | NBINS*CNT_W | Live bin counts of the second delay line |
| duty_cnt | input | $clog2(WIN_DEPTH+1) | Number of windowed hits taken while the clock was high |
| ev_valid | input | 1 | Event present this cycle |
| ev_code | input | $clog2(NBINS) | Encoded bin of the event |
| ev_sel | input | 1 | 0: first line, 1: second line (clock was high) |
| fine_valid | output | 1 | Calibrated result present |
| fine_time | output | CNT_W+$clog2(NBINS)+1 | Calibrated fine time in count units |

## Verification
A wrong partial sum in one Brent-Kung node corrupts only the table entries downstream of that node. It therefore appears at the ports only for codes whose prefix passes through it. The vector walk thus covers the lowest code, the highest code and codes in between on both lines. A fault in table swapping or pipeline depth shifts the cycle in which a histogram change first becomes visible. This shows up about 2·log2(NBINS) cycles after the change, and the bench samples on both sides of that point. A fault in the event stages shows within two cycles, as a missing, doubled or late `fine_valid`, or as a clock-low offset on the wrong line.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // True when a Brent-Kung node at column i adds its partner D columns below.
  function automatic bit node_adds(bit up, int d, int i);
    if (up) return ((i + 1) % (2 * d)) == 0;
    return (((i + 1) % (2 * d)) == d) && (i >= 3 * d - 1);
  endfunction

  // Clock-low interval in count units, clamped at zero.
  function automatic int unsigned low_gap(int unsigned depth, int unsigned duty);
    return (duty >= depth) ? 0 : depth - duty;
  endfunction

endpackage

// File: rtl/bk_prefix_pipe.sv
module bk_prefix_pipe
  import cal_pkg::*;
#(
  parameter int N = 128,
  parameter int W = 16,
  localparam int L = $clog2(N),
  localparam int SW = W + L,
  localparam int S = 2 * L - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*W-1:0]  din,
  output logic [N*SW-1:0] dout,
  output logic            dout_valid
);

  logic [N-1:0][SW-1:0] st [S];
  logic [S-1:0]         vld;

  for (genvar s = 0; s < S; s++) begin : g_stage
    localparam bit UP = (s < L);
    localparam int D = 1 << (UP ? s : (2 * L - 2 - s));
    logic [N-1:0][SW-1:0] src;

    if (s == 0) begin : g_first
      always_comb
        for (int i = 0; i < N; i++) src[i] = SW'(din[i*W +: W]);
    end else begin : g_next
      always_comb src = st[s-1];
    end

    always_ff @(posedge clk)
      for (int i = 0; i < N; i++) begin
        if (node_adds(UP, D, i)) st[s][i] <= src[i] + src[L'(i - D)];
        else                     st[s][i] <= src[i];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vld <= '0;
    else        vld <= {vld[S-2:0], 1'b1};

  assign dout       = st[S-1];
  assign dout_valid = vld[S-1];

  // R5: once the pipeline has filled it reports a result every cycle
  p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |=> dout_valid);

endmodule

// File: rtl/lut_bank.sv
module lut_bank #(
  parameter int N = 128,
  parameter int SW = 23,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [N*SW-1:0] shadow,
  input  logic [IW-1:0]   code,
  output logic [SW-1:0]   lo,
  output logic [SW-1:0]   hi
);

  logic [N-1:0][SW-1:0] tbl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    tbl <= '0;
    else if (load) tbl <= shadow;

  assign hi = tbl[code];
  assign lo = (code == '0) ? '0 : tbl[code - 1'b1];

  // R8: the active table only changes in a swap cycle
  p_atomic_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(tbl));

  // R1: running sums of non-negative counts never decrease along the table
  for (genvar i = 1; i < N; i++) begin : g_mono
    p_monotone_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tbl[i] >= tbl[i-1]);
  end

endmodule

// File: rtl/fine_time_calc.sv
module fine_time_calc
  import cal_pkg::*;
#(
  parameter int SW = 23,
  parameter int DW = 15,
  parameter int DEPTH = 20000,
  localparam int OW = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sel,
  input  logic [SW-1:0] lo_a,
  input  logic [SW-1:0] hi_a,
  input  logic [SW-1:0] lo_b,
  input  logic [SW-1:0] hi_b,
  input  logic [DW-1:0] duty,
  output logic          out_valid,
  output logic [OW-1:0] out_time
);

  logic          v1;
  logic [SW-1:0] lo1, hi1;
  logic [OW-1:0] off1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1        <= 1'b0;
      lo1       <= '0;
      hi1       <= '0;
      off1      <= '0;
      out_valid <= 1'b0;
      out_time  <= '0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
      if (in_valid) begin
        lo1  <= in_sel ? lo_b : lo_a;
        hi1  <= in_sel ? hi_b : hi_a;
        off1 <= in_sel ? OW'(low_gap(DEPTH, 32'(duty))) : '0;
      end
      if (v1) out_time <= OW'(lo1) + OW'((hi1 - lo1) >> 1) + off1;
    end

  // R1: the result lies inside the event's own bin (plus the offset)
  p_in_bin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> (out_time >= OW'($past(lo1)) + $past(off1)) &&
           (out_time <= OW'($past(hi1)) + $past(off1)));

  // R3: the clock-low interval never exceeds the window depth
  p_gap_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> off1 <= OW'(DEPTH));

endmodule

// File: rtl/calib_lut_builder.sv
module calib_lut_builder #(
  parameter int NBINS = 128,
  parameter int CNT_W = 16,
  parameter int WIN_DEPTH = 20000,
  localparam int CODE_W = $clog2(NBINS),
  localparam int SUM_W = CNT_W + CODE_W,
  localparam int OUT_W = SUM_W + 1,
  localparam int DUTY_W = $clog2(WIN_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NBINS*CNT_W-1:0] hist_a,
  input  logic [NBINS*CNT_W-1:0] hist_b,
  input  logic [DUTY_W-1:0]      duty_cnt,
  input  logic                   ev_valid,
  input  logic [CODE_W-1:0]      ev_code,
  input  logic                   ev_sel,
  output logic                   fine_valid,
  output logic [OUT_W-1:0]       fine_time
);

  logic [NBINS*SUM_W-1:0] sums_a, sums_b;
  logic                   done_a, done_b;
  logic [SUM_W-1:0]       lo_a, hi_a, lo_b, hi_b;

  bk_prefix_pipe #(.N(NBINS), .W(CNT_W)) u_pfx_a (
    .clk(clk), .rst_n(rst_n), .din(hist_a), .dout(sums_a), .dout_valid(done_a));
  bk_prefix_pipe #(.N(NBINS), .W(CNT_W)) u_pfx_b (
    .clk(clk), .rst_n(rst_n), .din(hist_b), .dout(sums_b), .dout_valid(done_b));

  lut_bank #(.N(NBINS), .SW(SUM_W)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .load(done_a), .shadow(sums_a),
    .code(ev_code), .lo(lo_a), .hi(hi_a));
  lut_bank #(.N(NBINS), .SW(SUM_W)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .load(done_b), .shadow(sums_b),
    .code(ev_code), .lo(lo_b), .hi(hi_b));

  fine_time_calc #(.SW(SUM_W), .DW(DUTY_W), .DEPTH(WIN_DEPTH)) u_calc (
    .clk(clk), .rst_n(rst_n), .in_valid(ev_valid), .in_sel(ev_sel),
    .lo_a(lo_a), .hi_a(hi_a), .lo_b(lo_b), .hi_b(hi_b), .duty(duty_cnt),
    .out_valid(fine_valid), .out_time(fine_time));

  // R4: every accepted event is answered exactly two edges later
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> ##1 fine_valid);
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> ##1 !fine_valid);

  // R8: both lines swap tables in lockstep
  p_swap_lockstep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_a == done_b);

endmodule

// File: tb/calib_lut_builder_bench.sv
module calib_lut_builder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 128;
  localparam int CW = 16;
  localparam int DEPTH = 20000;
  localparam int L = $clog2(NB);
  localparam int OW = CW + L + 1;
  localparam int DWW = $clog2(DEPTH + 1);
  localparam int NV = 8;
  localparam int VEC_CODE [NV] = '{0, 1, 63, 127, 0, 5, 90, 127};
  localparam bit VEC_SEL  [NV] = '{0, 0, 0, 0, 1, 1, 1, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NB*CW-1:0] hist_a = '0, hist_b = '0;
  logic [DWW-1:0] duty_cnt = '0;
  logic ev_valid = 1'b0, ev_sel = 1'b0;
  logic [L-1:0] ev_code = '0;
  logic fine_valid;
  logic [OW-1:0] fine_time;

  int ha [NB];
  int hb [NB];
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  calib_lut_builder #(.NBINS(NB), .CNT_W(CW), .WIN_DEPTH(DEPTH)) u_calib_lut_builder (
    .clk(clk), .rst_n(rst_n), .hist_a(hist_a), .hist_b(hist_b), .duty_cnt(duty_cnt),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_sel(ev_sel),
    .fine_valid(fine_valid), .fine_time(fine_time));

  task automatic chk(string req, longint got, longint exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint expect_time(int code, bit sel, int duty);
    longint acc = 0;
    for (int j = 0; j < code; j++) acc += sel ? hb[j] : ha[j];
    acc += (sel ? hb[code] : ha[code]) / 2;
    if (sel && duty < DEPTH) acc += DEPTH - duty;
    return acc;
  endfunction

  task automatic drive_hist();
    @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      hist_a[i*CW +: CW] = CW'(ha[i]);
      hist_b[i*CW +: CW] = CW'(hb[i]);
    end
  endtask

  // Drives one event at a falling edge; returns the result two edges later.
  task automatic run_event(string req, int code, bit sel, output longint got);
    @(negedge clk);
    ev_valid = 1'b1; ev_code = L'(code); ev_sel = sel;
    @(posedge clk); @(negedge clk);
    ev_valid = 1'b0;
    chk({req, " valid after one edge"}, fine_valid, 0);
    @(posedge clk); @(negedge clk);
    chk({req, " valid after two edges"}, fine_valid, 1);
    got = fine_time;
    @(posedge clk); @(negedge clk);
    chk({req, " valid drops"}, fine_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    longint got, e_old, e_new;
    int duty;
    for (int i = 0; i < NB; i++) begin
      ha[i] = (i * 37 + 5) % 200;
      hb[i] = 100 + (i % 7) * 3;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 valid low in reset", fine_valid, 0);
    rst_n = 1'b1;
    drive_hist();
    // R6: table still empty right after reset
    run_event("R6 empty table", 40, 0, got);
    chk("R6 empty table result", got, 0);

    repeat (2 * L + 4) @(posedge clk);

    // R1, R2: vector walk over both lines
    duty = 9000;
    duty_cnt = DWW'(duty);
    for (int v = 0; v < NV; v++) begin
      run_event(VEC_SEL[v] ? "R2 vector" : "R1 vector", VEC_CODE[v], VEC_SEL[v], got);
      chk(VEC_SEL[v] ? "R2 vector result" : "R1 vector result",
          got, expect_time(VEC_CODE[v], VEC_SEL[v], duty));
    end

    // R3: duty at and above the window depth gives no offset; zero gives full depth
    duty = DEPTH; duty_cnt = DWW'(duty);
    run_event("R3 duty equal", 20, 1, got);
    chk("R3 duty equal result", got, expect_time(20, 1, 0) - DEPTH);
    duty = DEPTH + 100; duty_cnt = DWW'(duty);
    run_event("R3 duty above", 20, 1, got);
    chk("R3 duty above result", got, expect_time(20, 1, 0) - DEPTH);
    duty = 0; duty_cnt = '0;
    run_event("R2 duty zero", 20, 1, got);
    chk("R2 duty zero result", got, expect_time(20, 1, 0));

    // R4: back-to-back events answered in order
    duty = 1234; duty_cnt = DWW'(duty);
    @(negedge clk); ev_valid = 1'b1; ev_code = 7'd10; ev_sel = 1'b0;
    @(negedge clk); ev_code = 7'd11; ev_sel = 1'b1;
    chk("R4 burst no early valid", fine_valid, 0);
    @(negedge clk); ev_code = 7'd12; ev_sel = 1'b0;
    chk("R4 burst first valid", fine_valid, 1);
    chk("R4 burst first", fine_time, expect_time(10, 0, duty));
    @(negedge clk); ev_valid = 1'b0;
    chk("R4 burst second valid", fine_valid, 1);
    chk("R4 burst second", fine_time, expect_time(11, 1, duty));
    @(negedge clk);
    chk("R4 burst third valid", fine_valid, 1);
    chk("R4 burst third", fine_time, expect_time(12, 0, duty));
    @(negedge clk);
    chk("R4 burst ends", fine_valid, 0);

    // R5, R8: histogram change timing
    e_old = expect_time(64, 0, 0);
    for (int i = 0; i < NB; i++) ha[i] = 50 + (i * 11) % 90;
    e_new = expect_time(64, 0, 0);
    drive_hist();
    repeat (2 * L - 3) @(posedge clk);
    run_event("R5 before refresh", 64, 0, got);
    chk("R5 old table in use", got, e_old);
    for (int i = 0; i < NB; i++) hb[i] = 30 + (i * 5) % 61;
    drive_hist();
    repeat (2 * L + 2) @(posedge clk);
    run_event("R5 after refresh", 64, 1, got);
    chk("R5 new table in use", got, expect_time(64, 1, duty));
    run_event("R8 low entry", 0, 0, got);
    chk("R8 low entry result", got, expect_time(0, 0, 0));
    run_event("R8 high entry", 127, 0, got);
    chk("R8 high entry result", got, expect_time(127, 0, 0));

    // R7: full-scale counts
    for (int i = 0; i < NB; i++) begin ha[i] = 65535; hb[i] = 65535; end
    drive_hist();
    duty = 0; duty_cnt = '0;
    repeat (2 * L + 4) @(posedge clk);
    run_event("R7 full scale a", 127, 0, got);
    chk("R7 full scale a result", got, 64'd8355712);
    run_event("R7 full scale b", 127, 1, got);
    chk("R7 full scale b result", got, 64'd8375712);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule